// File: doc/BRIEF.md
# Glyph Address Mapper

This block sits behind a character-cell video controller. It turns the controller's page addresses and cell-line indices into accesses to three storage arrays. The first is page storage, which holds one character code per screen cell. The second is glyph storage, which holds the dot rows of each character. The third is a one-bit colour store that runs alongside glyph storage.

A glyph access is indirect. The page byte at the given page address is the character code. That code, shifted left by three and joined with the 3-bit line index, is the glyph address. On every glyph write the processor's Q status flag is stored into the colour store at that same address. On every glyph read the matching colour bit is latched onto a status output.

A mode input sets how page storage is sized. In half mode only the lower half of page storage (1 KB) is mapped, and the upper half is treated as empty. In full mode the whole 2 KB is mapped.

Top module: `glyph_addr_mapper`

## Requirements
- R1: While reset is asserted and right after it is released, `page_rdata_o`, `pat_rdata_o` and `color_bit_o` are all zero.
- R2: In full mode (`wide_page_i`=1), a page read returns on `page_rdata_o`, one clock after the request, the byte last written to that address, for all 2048 addresses. `page_rdata_o` holds its value in every cycle without a page read.
- R3: In half mode (`wide_page_i`=0), a page read whose address bit 10 is 1 returns 0xFF.
- R4: In half mode, a page write whose address bit 10 is 1 changes no stored byte: neither that address nor its alias with bit 10 cleared.
- R5: In half mode, a page access whose address bit 10 is 0 reaches the same storage that full mode reaches at that address.
- R6: A glyph read uses glyph address = {page byte at `pat_page_addr_i`, `pat_line_i`} (code in bits 10..3, line in bits 2..0). Its data appears on `pat_rdata_o` two clocks after the request and holds until the next glyph read.
- R7: A glyph write stores `pat_wdata_i` at the glyph address. It also stores `cpu_q_i`, as sampled with the request, into the colour store at that same address.
- R8: A glyph read puts the stored colour bit on `color_bit_o` together with the glyph data. The bit holds through glyph writes and idle cycles.
- R9: In half mode, a glyph access whose page address bit 10 is 1 uses 0xFF as the character code, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_page_i | input | 1 | 1: 2 KB page storage; 0: lower 1 KB mapped, upper half empty |
| cpu_q_i | input | 1 | Processor Q flag, stored into the colour store on glyph writes |
| page_req_i | input | 1 | Page access strobe |
| page_we_i | input | 1 | Page access is a write |
| page_addr_i | input | 11 | Page address |
| page_wdata_i | input | 8 | Page write data |
| page_rdata_o | output | 8 | Page read data, one clock after the request |
| pat_req_i | input | 1 | Glyph access strobe |
| pat_we_i | input | 1 | Glyph access is a write |
| pat_page_addr_i | input | 11 | Page address that selects the character code |
| pat_line_i | input | 3 | Line index within the glyph |
| pat_wdata_i | input | 8 | Glyph write data |
| pat_rdata_o | output | 8 | Glyph read data, two clocks after the request |
| color_bit_o | output | 1 | Colour bit latched by the last glyph read |

## Verification
The bench builds the block with its default parameters: an 11-bit page address, an 8-bit character code and a 3-bit line index. At these sizes every one of the 2048 page locations and every one of the 2048 glyph/colour locations can be written and read back against an arithmetic model. Loading page codes 0..255 makes each glyph address reachable through the page indirection. The half-mode cases are then run over a slice of the upper half, with full-mode read-back afterwards to show which storage was left untouched.

// File: rtl/gam_pkg.sv
package gam_pkg;
  typedef enum logic {
    PAGE_HALF = 1'b0,
    PAGE_FULL = 1'b1
  } page_mode_e;

  localparam int unsigned DEF_PAGE_AW = 11;
  localparam int unsigned DEF_CODE_W  = 8;
  localparam int unsigned DEF_LINE_W  = 3;
  localparam int unsigned DEF_PAT_DW  = 8;
endpackage

// File: rtl/gam_page_store.sv
module gam_page_store
  import gam_pkg::*;
#(
  parameter int unsigned AW = DEF_PAGE_AW,
  parameter int unsigned DW = DEF_CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          look_req_i,
  input  logic [AW-1:0] look_addr_i,
  output logic [DW-1:0] code_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic          cpu_empty, look_empty;
  logic [AW-1:0] cpu_idx, look_idx;

  // half mode: top address bit selects the empty region, index masked below it
  always_comb begin
    cpu_empty  = (page_mode_e'(wide_i) == PAGE_HALF) && cpu_addr_i[AW-1];
    look_empty = (page_mode_e'(wide_i) == PAGE_HALF) && look_addr_i[AW-1];
    cpu_idx    = wide_i ? cpu_addr_i  : {1'b0, cpu_addr_i[AW-2:0]};
    look_idx   = wide_i ? look_addr_i : {1'b0, look_addr_i[AW-2:0]};
  end

  always_ff @(posedge clk_i) begin
    if (cpu_req_i && cpu_we_i && !cpu_empty) mem_q[cpu_idx] <= cpu_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rdata_o <= '0;
      code_o      <= '0;
    end else begin
      if (cpu_req_i && !cpu_we_i) cpu_rdata_o <= cpu_empty ? '1 : mem_q[cpu_idx];
      if (look_req_i)             code_o      <= look_empty ? '1 : mem_q[look_idx];
    end
  end
endmodule

// File: rtl/gam_glyph_store.sv
module gam_glyph_store
  import gam_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned DW     = DEF_PAT_DW,
  parameter int unsigned AW     = CODE_W + LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              q_i,
  output logic [DW-1:0]     rdata_o,
  output logic              color_o
);
  localparam int unsigned FW    = CODE_W + LINE_W;
  localparam int unsigned DEPTH = 1 << AW;

  logic [FW-1:0] full_addr;
  logic [AW-1:0] addr;
  logic [DW-1:0] pat_q [DEPTH];
  logic          col_q [DEPTH];

  assign full_addr = {code_i, line_i};

  generate
    if (AW >= FW) begin : g_pad
      assign addr = AW'(full_addr);
    end else begin : g_trim
      assign addr = full_addr[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (vld_i && we_i) begin
      pat_q[addr] <= wdata_i;
      col_q[addr] <= q_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      color_o <= 1'b0;
    end else if (vld_i && !we_i) begin
      rdata_o <= pat_q[addr];
      color_o <= col_q[addr];
    end
  end
endmodule

// File: rtl/glyph_addr_mapper.sv
module glyph_addr_mapper
  import gam_pkg::*;
#(
  parameter int unsigned PAGE_AW = DEF_PAGE_AW,
  parameter int unsigned CODE_W  = DEF_CODE_W,
  parameter int unsigned LINE_W  = DEF_LINE_W,
  parameter int unsigned PAT_DW  = DEF_PAT_DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wide_page_i,
  input  logic               cpu_q_i,
  input  logic               page_req_i,
  input  logic               page_we_i,
  input  logic [PAGE_AW-1:0] page_addr_i,
  input  logic [CODE_W-1:0]  page_wdata_i,
  output logic [CODE_W-1:0]  page_rdata_o,
  input  logic               pat_req_i,
  input  logic               pat_we_i,
  input  logic [PAGE_AW-1:0] pat_page_addr_i,
  input  logic [LINE_W-1:0]  pat_line_i,
  input  logic [PAT_DW-1:0]  pat_wdata_i,
  output logic [PAT_DW-1:0]  pat_rdata_o,
  output logic               color_bit_o
);
  localparam int unsigned GLYPH_AW = CODE_W + LINE_W;

  logic [CODE_W-1:0] s1_code;
  logic              s1_vld, s1_we, s1_q;
  logic [LINE_W-1:0] s1_line;
  logic [PAT_DW-1:0] s1_wdata;

  gam_page_store #(.AW(PAGE_AW), .DW(CODE_W)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wide_i      (wide_page_i),
    .cpu_req_i   (page_req_i),
    .cpu_we_i    (page_we_i),
    .cpu_addr_i  (page_addr_i),
    .cpu_wdata_i (page_wdata_i),
    .cpu_rdata_o (page_rdata_o),
    .look_req_i  (pat_req_i),
    .look_addr_i (pat_page_addr_i),
    .code_o      (s1_code)
  );

  // stage 1: align access control with the looked-up code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_we    <= 1'b0;
      s1_q     <= 1'b0;
      s1_line  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_vld <= pat_req_i;
      if (pat_req_i) begin
        s1_we    <= pat_we_i;
        s1_q     <= cpu_q_i;
        s1_line  <= pat_line_i;
        s1_wdata <= pat_wdata_i;
      end
    end
  end

  gam_glyph_store #(
    .CODE_W (CODE_W),
    .LINE_W (LINE_W),
    .DW     (PAT_DW),
    .AW     (GLYPH_AW)
  ) u_glyph (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_vld),
    .we_i    (s1_we),
    .code_i  (s1_code),
    .line_i  (s1_line),
    .wdata_i (s1_wdata),
    .q_i     (s1_q),
    .rdata_o (pat_rdata_o),
    .color_o (color_bit_o)
  );
endmodule

// File: rtl/glyph_addr_mapper_chk.sv
module glyph_addr_mapper_chk #(
  parameter int unsigned PAGE_AW = 11,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned PAT_DW  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wide_page_i,
  input logic               page_req_i,
  input logic               page_we_i,
  input logic [PAGE_AW-1:0] page_addr_i,
  input logic [CODE_W-1:0]  page_rdata_o,
  input logic               pat_req_i,
  input logic               pat_we_i,
  input logic [PAT_DW-1:0]  pat_rdata_o,
  input logic               color_bit_o
);
  logic rd_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_d1 <= 1'b0;
    else         rd_d1 <= pat_req_i && !pat_we_i;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_reset_zero_r1: assert (page_rdata_o == '0 && pat_rdata_o == '0 && color_bit_o == 1'b0)
        else $error("outputs not cleared in reset");
    end
  end

  p_empty_read_ff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_req_i && !page_we_i && !wide_page_i && page_addr_i[PAGE_AW-1]) |=> (page_rdata_o == '1));

  p_page_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(page_req_i && !page_we_i) |=> $stable(page_rdata_o));

  p_pat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_d1 |=> $stable(pat_rdata_o));

  p_color_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_d1 |=> $stable(color_bit_o));
endmodule

bind glyph_addr_mapper glyph_addr_mapper_chk #(
  .PAGE_AW (PAGE_AW),
  .CODE_W  (CODE_W),
  .PAT_DW  (PAT_DW)
) u_chk (.*);

// File: tb/sim_glyph_addr_mapper.sv
module sim_glyph_addr_mapper;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide = 1'b1, cpu_q = 1'b0;
  logic        page_req = 1'b0, page_we = 1'b0;
  logic [10:0] page_addr = '0;
  logic [7:0]  page_wd = '0;
  logic [7:0]  page_rd;
  logic        pat_req = 1'b0, pat_we = 1'b0;
  logic [10:0] pat_pa = '0;
  logic [2:0]  pat_ln = '0;
  logic [7:0]  pat_wd = '0;
  logic [7:0]  pat_rd;
  logic        color;

  logic [7:0] page_m [2048];
  logic [7:0] pat_m  [2048];
  logic       col_m  [2048];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  glyph_addr_mapper u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wide_page_i(wide), .cpu_q_i(cpu_q),
    .page_req_i(page_req), .page_we_i(page_we), .page_addr_i(page_addr),
    .page_wdata_i(page_wd), .page_rdata_o(page_rd),
    .pat_req_i(pat_req), .pat_we_i(pat_we), .pat_page_addr_i(pat_pa),
    .pat_line_i(pat_ln), .pat_wdata_i(pat_wd), .pat_rdata_o(pat_rd),
    .color_bit_o(color)
  );

  function automatic logic [7:0] pg_val(int a);
    return 8'((a * 29) + (a >> 3) + 7);
  endfunction
  function automatic logic [7:0] gl_val(int a);
    return 8'((a * 13) ^ (a >> 5) ^ 8'h5C);
  endfunction
  function automatic bit q_of(int a);
    return ^11'(a);
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic page_op(input bit we, input int a, input logic [7:0] d);
    @(negedge clk);
    page_req = 1'b1; page_we = we; page_addr = 11'(a); page_wd = d;
    @(negedge clk);
    page_req = 1'b0; page_we = 1'b0;
  endtask

  task automatic pat_op(input bit we, input int pa, input int ln, input logic [7:0] d, input bit q);
    @(negedge clk);
    pat_req = 1'b1; pat_we = we; pat_pa = 11'(pa); pat_ln = 3'(ln); pat_wd = d; cpu_q = q;
    @(negedge clk);
    pat_req = 1'b0; pat_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(page_rd == 8'h00, "R1 page_rdata", page_rd, 0);
    check(pat_rd == 8'h00, "R1 pat_rdata", pat_rd, 0);
    check(color == 1'b0, "R1 color_bit", color, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(page_rd == 8'h00 && pat_rd == 8'h00 && color == 1'b0, "R1 after release",
          {page_rd, pat_rd, 7'b0, color}, 0);

    // R2: full-mode sweep of page storage
    wide = 1'b1;
    for (int a = 0; a < 2048; a++) begin
      page_op(1'b1, a, pg_val(a));
      page_m[a] = pg_val(a);
    end
    for (int a = 0; a < 2048; a++) begin
      page_op(1'b0, a, 8'h00);
      check(page_rd == page_m[a], "R2 page read", page_rd, page_m[a]);
    end
    @(negedge clk);
    check(page_rd == page_m[2047], "R2 page hold", page_rd, page_m[2047]);

    // codes 0..255 at page 0..255 reach every glyph address
    for (int c = 0; c < 256; c++) begin
      page_op(1'b1, c, 8'(c));
      page_m[c] = 8'(c);
    end

    // R7: glyph write sweep with Q from address parity
    for (int g = 0; g < 2048; g++) begin
      pat_op(1'b1, g >> 3, g & 7, gl_val(g), q_of(g));
      pat_m[g] = gl_val(g);
      col_m[g] = q_of(g);
    end
    // R6/R7/R8: glyph read sweep
    for (int g = 0; g < 2048; g++) begin
      pat_op(1'b0, g >> 3, g & 7, 8'h00, 1'b0);
      check(pat_rd == pat_m[g], "R6 glyph read", pat_rd, pat_m[g]);
      check(color == col_m[g], "R7 colour bit", color, col_m[g]);
    end

    // R8: colour and glyph data hold through writes and idle
    pat_op(1'b0, 0, 1, 8'h00, 1'b0);
    check(color == 1'b1, "R8 colour latch", color, 1);
    pat_op(1'b1, 0, 0, pat_m[0], 1'b0);
    check(color == 1'b1, "R8 colour hold after write", color, 1);
    check(pat_rd == pat_m[1], "R6 glyph hold after write", pat_rd, pat_m[1]);
    repeat (4) @(negedge clk);
    check(color == 1'b1, "R8 colour hold idle", color, 1);

    // R3/R5: half-mode reads
    wide = 1'b0;
    for (int k = 0; k < 64; k++) begin
      page_op(1'b0, 11'h400 | k, 8'h00);
      check(page_rd == 8'hFF, "R3 empty half reads 0xFF", page_rd, 8'hFF);
      page_op(1'b0, 300 + k, 8'h00);
      check(page_rd == page_m[300 + k], "R5 half-mode low read", page_rd, page_m[300 + k]);
    end
    // R5: half-mode writes to the lower half
    for (int k = 0; k < 16; k++) begin
      page_op(1'b1, 600 + k, 8'(8'hC0 + k));
      page_m[600 + k] = 8'(8'hC0 + k);
    end
    // R4: writes into the empty half
    for (int k = 16; k < 64; k++) page_op(1'b1, 11'h400 | (600 + k - 512), 8'hA5);
    wide = 1'b1;
    for (int k = 0; k < 16; k++) begin
      page_op(1'b0, 600 + k, 8'h00);
      check(page_rd == page_m[600 + k], "R5 half write seen in full mode", page_rd, page_m[600 + k]);
    end
    for (int k = 16; k < 64; k++) begin
      page_op(1'b0, 11'h400 | (600 + k - 512), 8'h00);
      check(page_rd == page_m[11'h400 | (600 + k - 512)], "R4 empty write ignored",
            page_rd, page_m[11'h400 | (600 + k - 512)]);
      page_op(1'b0, 600 + k - 512, 8'h00);
      check(page_rd == page_m[600 + k - 512], "R4 alias untouched", page_rd, page_m[600 + k - 512]);
    end

    // R9: half-mode glyph access through the empty half uses code 0xFF
    page_op(1'b1, 11'h405, 8'h12);
    page_m[11'h405] = 8'h12;
    wide = 1'b0;
    for (int l = 0; l < 8; l++) begin
      pat_op(1'b0, 11'h405, l, 8'h00, 1'b0);
      check(pat_rd == pat_m[11'h7F8 | l], "R9 code 0xFF read", pat_rd, pat_m[11'h7F8 | l]);
      check(color == col_m[11'h7F8 | l], "R9 code 0xFF colour", color, col_m[11'h7F8 | l]);
    end
    pat_op(1'b1, 11'h405, 3, 8'h3C, ~col_m[11'h7FB]);
    pat_m[11'h7FB] = 8'h3C;
    col_m[11'h7FB] = ~col_m[11'h7FB];
    wide = 1'b1;
    pat_op(1'b0, 255, 3, 8'h00, 1'b0);
    check(pat_rd == 8'h3C, "R9 code 0xFF write", pat_rd, 8'h3C);
    check(color == col_m[11'h7FB], "R9 code 0xFF write colour", color, col_m[11'h7FB]);
    // R6: full mode uses the stored upper-half code
    for (int l = 0; l < 8; l++) begin
      pat_op(1'b0, 11'h405, l, 8'h00, 1'b0);
      check(pat_rd == pat_m[(8'h12 << 3) | l], "R6 upper-half code", pat_rd, pat_m[(8'h12 << 3) | l]);
    end

    done = 1'b1;
    report();
  end
endmodule